// File: doc/BRIEF.md
# UART Interrupt Enable and Status Bank

This block gathers thirteen single-cycle event pulses from a UART's transmit, receive and modem logic into one level-sensitive interrupt line. Each event sets its own sticky status bit. The bit stays set until software clears it. The interrupt line is raised when any status bit is pending and that bit is unmasked.

Software sees four 32-bit registers through a plain register bus made of an address, a write strobe, write data and combinational read data. The mask is never written directly. One address sets mask bits for each one written to it. A second address clears mask bits for each one written to it. A third address returns the current mask and ignores writes. A fourth address returns the pending status, and writing ones to it clears the matching bits. A driver can mask and clear every source by writing all thirteen ones to the disable address and then to the status address.

Top module: `uirq_bank`

## Requirements
- R1: After synchronous reset the mask, the status and `irq_out` are all zero.
- R2: A write to address 0x08 sets every mask bit whose write-data bit is one and leaves the others unchanged. The new mask reads back at address 0x10 in the cycle after the write.
- R3: A write to address 0x0C clears every mask bit whose write-data bit is one and leaves the others unchanged.
- R4: A one-cycle pulse on `evt_pulse[i]` sets status bit i whether or not bit i is masked. The bit stays set on later cycles and reads back at address 0x14.
- R5: A write to address 0x14 clears every status bit whose write-data bit is one. Status bits written with zero keep their value.
- R6: If an event pulse arrives on a bit in the same cycle as a clearing write to that bit, the bit stays set.
- R7: `irq_out` is a register. It is one in the cycle after the cycle in which (status AND mask) is nonzero, and zero in the cycle after the cycle in which that AND is zero.
- R8: The sources take bits 12 down to 0 in this order: tx overflow (12), tx nearly full (11), tx trigger (10), modem status change (9), rx timeout (8), parity error (7), framing error (6), rx overflow (5), tx full (4), tx empty (3), rx full (2), rx empty (1), rx trigger (0). Read bits 31..13 are always zero.
- R9: Writes to the mask readback address 0x10 have no effect. Reads of the enable address 0x08 and the disable address 0x0C return zero.
- R10: Writing 0x1FFF to address 0x0C and then to address 0x14 leaves the mask and the status at zero, and `irq_out` falls to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 8 | Register byte address |
| bus_we | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| evt_pulse | input | 13 | Single-cycle event pulses, one per source |
| irq_out | output | 1 | Registered level interrupt |

## Verification
The bench concentrates on the corners where a plausible bug stays quiet:
- **Collision.** An event pulse lands in the same cycle as a clearing write to that bit. A design that lets the clear win would lose the event, and the status readback would come back zero.
- **Zero bits in enable, disable and clear writes.** The bench writes patterns with zeros in them. A design that assigns the write data directly, instead of setting or clearing bit by bit, would drop mask or status bits that should have survived.
- **Interrupt latency.** The bench samples `irq_out` exactly one cycle after status or mask changes, both on the cycle before the change and on the cycle after it. A design that drives the interrupt combinationally would be caught early, and one with an extra register stage would be caught late.
- **Capture while masked.** The bench pulses masked sources and then unmasks them. A design that gated capture with the mask would show no status and raise no interrupt.

// File: rtl/uirq_pkg.sv
package uirq_pkg;

    localparam int NSRC_DEF   = 13;
    localparam int ADDR_W_DEF = 8;
    localparam int DATA_W_DEF = 32;

    localparam logic [ADDR_W_DEF-1:0] OFS_SET  = 8'h08;
    localparam logic [ADDR_W_DEF-1:0] OFS_CLR  = 8'h0C;
    localparam logic [ADDR_W_DEF-1:0] OFS_MASK = 8'h10;
    localparam logic [ADDR_W_DEF-1:0] OFS_STAT = 8'h14;

    // Bit index of each event source
    typedef enum int {
        SRC_RX_TRIG   = 0,
        SRC_RX_EMPTY  = 1,
        SRC_RX_FULL   = 2,
        SRC_TX_EMPTY  = 3,
        SRC_TX_FULL   = 4,
        SRC_RX_OVR    = 5,
        SRC_FRAME_ERR = 6,
        SRC_PAR_ERR   = 7,
        SRC_RX_TMO    = 8,
        SRC_MODEM_CHG = 9,
        SRC_TX_TRIG   = 10,
        SRC_TX_NFULL  = 11,
        SRC_TX_OVR    = 12
    } src_idx_e;

    // Decoded write strobes for one bus cycle
    typedef struct packed {
        logic set_mask;
        logic clr_mask;
        logic clr_stat;
    } wr_strobe_t;

    function automatic logic addr_hit(input logic [ADDR_W_DEF-1:0] a,
                                      input logic [ADDR_W_DEF-1:0] ofs);
        return a == ofs;
    endfunction

endpackage

// File: rtl/uirq_regdec.sv
module uirq_regdec
    import uirq_pkg::*;
#(
    parameter int ADDR_W = ADDR_W_DEF
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              we,
    output wr_strobe_t        strb
);
    always_comb begin
        strb          = '0;
        strb.set_mask = we && addr_hit(addr, OFS_SET);
        strb.clr_mask = we && addr_hit(addr, OFS_CLR);
        strb.clr_stat = we && addr_hit(addr, OFS_STAT);
    end
endmodule

// File: rtl/uirq_mask.sv
module uirq_mask #(
    parameter int NSRC = 13
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            set_en,
    input  logic            clr_en,
    input  logic [NSRC-1:0] bits,
    output logic [NSRC-1:0] mask
);
    logic [NSRC-1:0] set_v;
    logic [NSRC-1:0] clr_v;

    assign set_v = set_en ? bits : '0;
    assign clr_v = clr_en ? bits : '0;

    always_ff @(posedge clk) begin
        if (rst) mask <= '0;
        else     mask <= (mask | set_v) & ~clr_v;
    end
endmodule

// File: rtl/uirq_status.sv
module uirq_status #(
    parameter int NSRC = 13
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            clr_en,
    input  logic [NSRC-1:0] clr_bits,
    input  logic [NSRC-1:0] evt,
    output logic [NSRC-1:0] stat
);
    for (genvar i = 0; i < NSRC; i++) begin : g_bit
        always_ff @(posedge clk) begin
            if (rst)
                stat[i] <= 1'b0;
            else if (evt[i])
                stat[i] <= 1'b1;          // a new event beats a clear
            else if (clr_en && clr_bits[i])
                stat[i] <= 1'b0;
        end
    end
endmodule

// File: rtl/uirq_bank.sv
module uirq_bank
    import uirq_pkg::*;
#(
    parameter int NSRC   = NSRC_DEF,
    parameter int ADDR_W = ADDR_W_DEF,
    parameter int DATA_W = DATA_W_DEF
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic [NSRC-1:0]   evt_pulse,
    output logic              irq_out
);
    localparam int PAD_W = DATA_W - NSRC;

    wr_strobe_t      strb;
    logic [NSRC-1:0] wbits;
    logic [NSRC-1:0] mask_q;
    logic [NSRC-1:0] status_q;
    logic            unused_wdata_hi;

    assign wbits           = bus_wdata[NSRC-1:0];
    assign unused_wdata_hi = ^bus_wdata[DATA_W-1:NSRC];

    uirq_regdec #(.ADDR_W(ADDR_W)) u_dec (
        .addr (bus_addr),
        .we   (bus_we),
        .strb (strb)
    );

    uirq_mask #(.NSRC(NSRC)) u_mask (
        .clk    (clk),
        .rst    (rst),
        .set_en (strb.set_mask),
        .clr_en (strb.clr_mask),
        .bits   (wbits),
        .mask   (mask_q)
    );

    uirq_status #(.NSRC(NSRC)) u_stat (
        .clk      (clk),
        .rst      (rst),
        .clr_en   (strb.clr_stat),
        .clr_bits (wbits),
        .evt      (evt_pulse),
        .stat     (status_q)
    );

    always_ff @(posedge clk) begin
        if (rst) irq_out <= 1'b0;
        else     irq_out <= |(status_q & mask_q);
    end

    always_comb begin
        if (addr_hit(bus_addr, OFS_MASK))
            bus_rdata = {{PAD_W{1'b0}}, mask_q};
        else if (addr_hit(bus_addr, OFS_STAT))
            bus_rdata = {{PAD_W{1'b0}}, status_q};
        else
            bus_rdata = '0;
    end
endmodule

// File: rtl/uirq_bank_chk.sv
module uirq_bank_chk
    import uirq_pkg::*;
#(
    parameter int NSRC   = NSRC_DEF,
    parameter int ADDR_W = ADDR_W_DEF,
    parameter int DATA_W = DATA_W_DEF
) (
    input logic              clk,
    input logic              rst,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_we,
    input logic [DATA_W-1:0] bus_wdata,
    input logic [NSRC-1:0]   evt_pulse,
    input logic              irq_out,
    input logic [NSRC-1:0]   mask_q,
    input logic [NSRC-1:0]   status_q
);
    p_reset_clears_r1: assert property (@(posedge clk)
        rst |=> (mask_q == '0 && status_q == '0 && !irq_out));

    p_set_mask_r2: assert property (@(posedge clk) disable iff (rst)
        (bus_we && bus_addr == OFS_SET) |=>
            ((mask_q & $past(bus_wdata[NSRC-1:0])) == $past(bus_wdata[NSRC-1:0])));

    p_clr_mask_r3: assert property (@(posedge clk) disable iff (rst)
        (bus_we && bus_addr == OFS_CLR) |=>
            ((mask_q & $past(bus_wdata[NSRC-1:0])) == '0));

    p_capture_r4: assert property (@(posedge clk) disable iff (rst)
        (evt_pulse != '0) |=>
            ((status_q & $past(evt_pulse)) == $past(evt_pulse)));

    p_w1c_r5: assert property (@(posedge clk) disable iff (rst)
        (bus_we && bus_addr == OFS_STAT && evt_pulse == '0) |=>
            ((status_q & $past(bus_wdata[NSRC-1:0])) == '0));

    p_irq_level_r7: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (irq_out == $past(|(status_q & mask_q))));

    p_mask_hold_r9: assert property (@(posedge clk) disable iff (rst)
        !(bus_we && (bus_addr == OFS_SET || bus_addr == OFS_CLR)) |=> $stable(mask_q));
endmodule

bind uirq_bank uirq_bank_chk #(.NSRC(NSRC), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .bus_addr  (bus_addr),
    .bus_we    (bus_we),
    .bus_wdata (bus_wdata),
    .evt_pulse (evt_pulse),
    .irq_out   (irq_out),
    .mask_q    (mask_q),
    .status_q  (status_q)
);

// File: tb/uirq_bank_test.sv
module uirq_bank_test;
    localparam int NSRC = 13;
    localparam logic [7:0] A_SET  = 8'h08;
    localparam logic [7:0] A_CLR  = 8'h0C;
    localparam logic [7:0] A_MASK = 8'h10;
    localparam logic [7:0] A_STAT = 8'h14;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic [7:0]      bus_addr = '0;
    logic            bus_we = 1'b0;
    logic [31:0]     bus_wdata = '0;
    logic [31:0]     bus_rdata;
    logic [NSRC-1:0] evt_pulse = '0;
    logic            irq_out;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;   // 50 MHz

    uirq_bank uut (
        .clk       (clk),
        .rst       (rst),
        .bus_addr  (bus_addr),
        .bus_we    (bus_we),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .evt_pulse (evt_pulse),
        .irq_out   (irq_out)
    );

    task automatic check(input bit ok, input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_we = 1'b1; bus_wdata = d;
        @(negedge clk);
        bus_we = 1'b0; bus_wdata = '0;
    endtask

    task automatic pulse(input logic [NSRC-1:0] e);
        @(negedge clk);
        evt_pulse = e;
        @(negedge clk);
        evt_pulse = '0;
    endtask

    task automatic rd_check(input logic [7:0] a, input logic [31:0] exp, input string req);
        bus_addr = a;
        #1;
        check(bus_rdata == exp, req, bus_rdata, exp);
    endtask

    task automatic irq_check(input bit exp, input string req);
        check(irq_out == exp, req, {31'b0, irq_out}, {31'b0, exp});
    endtask

    task automatic t_reset;
        rd_check(A_MASK, 32'h0, "R1 mask after reset");
        rd_check(A_STAT, 32'h0, "R1 status after reset");
        irq_check(1'b0, "R1 irq after reset");
    endtask

    task automatic t_enable_disable;
        wr(A_SET, 32'h0000_0005);
        rd_check(A_MASK, 32'h5, "R2 enable sets bits");
        wr(A_SET, 32'h0000_0100);
        rd_check(A_MASK, 32'h105, "R2 zero bits keep mask");
        wr(A_CLR, 32'h0000_0004);
        rd_check(A_MASK, 32'h101, "R3 disable clears bits");
    endtask

    task automatic t_sticky_irq;
        // bit 3 (tx empty) is masked off
        pulse(13'h0008);
        repeat (3) @(negedge clk);
        rd_check(A_STAT, 32'h8, "R4 masked source captured and held");
        irq_check(1'b0, "R7 no irq for masked source");
        // bit 0 (rx trigger) is enabled
        pulse(13'h0001);
        irq_check(1'b0, "R7 irq one cycle after status");
        @(negedge clk);
        irq_check(1'b1, "R7 irq raised");
        wr(A_STAT, 32'h0000_0001);
        rd_check(A_STAT, 32'h8, "R5 w1c clears only written bit");
        irq_check(1'b1, "R7 irq still high one cycle after clear");
        @(negedge clk);
        irq_check(1'b0, "R7 irq falls");
        wr(A_SET, 32'h0000_0008);
        @(negedge clk);
        irq_check(1'b1, "R4 unmasking pending bit raises irq");
        wr(A_CLR, 32'h0000_0008);
        wr(A_STAT, 32'h0000_0008);
    endtask

    task automatic t_collision;
        pulse(13'h0040);
        @(negedge clk);
        bus_addr = A_STAT; bus_we = 1'b1; bus_wdata = 32'h40;
        evt_pulse = 13'h0040;
        @(negedge clk);
        bus_we = 1'b0; bus_wdata = '0; evt_pulse = '0;
        rd_check(A_STAT, 32'h40, "R6 event beats clear");
        wr(A_STAT, 32'h40);
        rd_check(A_STAT, 32'h0, "R5 bit cleared afterwards");
    endtask

    task automatic t_order_ro;
        pulse(13'h1000);
        rd_check(A_STAT, 32'h1000, "R8 tx overflow is bit 12");
        wr(A_STAT, 32'hFFFF_FFFF);
        wr(A_SET, 32'hFFFF_FFFF);
        rd_check(A_MASK, 32'h1FFF, "R8 upper mask bits read zero");
        rd_check(A_SET, 32'h0, "R9 enable address reads zero");
        rd_check(A_CLR, 32'h0, "R9 disable address reads zero");
        wr(A_MASK, 32'h0);
        rd_check(A_MASK, 32'h1FFF, "R9 write to mask readback ignored");
    endtask

    task automatic t_all_clear;
        pulse(13'h1FFF);
        rd_check(A_STAT, 32'h1FFF, "R4 all sources captured");
        @(negedge clk);
        irq_check(1'b1, "R10 irq high before clear");
        wr(A_CLR, 32'h1FFF);
        wr(A_STAT, 32'h1FFF);
        rd_check(A_MASK, 32'h0, "R10 mask cleared");
        rd_check(A_STAT, 32'h0, "R10 status cleared");
        @(negedge clk);
        irq_check(1'b0, "R10 irq low");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_enable_disable();
        t_sticky_irq();
        t_collision();
        t_order_ro();
        t_all_clear();
        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            failures++;
            $display("FAIL watchdog actual=0x1 expected=0x0");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule